// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers seventeen external request pins into a single prioritised request for a CPU. One pin is non-maskable. The other sixteen are maskable request pins numbered 0 to 15. Every pin passes through a two-stage synchroniser before its events are detected. Because detection works on the synchronised pin value, it does not matter whether the pad is driven by the chip or from outside.

Each maskable pin has four settings:
- a sense mode: low level, falling edge, rising edge, or both edges;
- an enable bit;
- a 3-bit priority level, where level 0 masks the pin;
- a pending flag.

Software clears a pending flag with a two-step handshake. It first reads the status register, then writes 0 to a bit that the read returned as 1. The non-maskable pin has one control bit that picks its active edge. When that pin is pending it always wins over every maskable request.

The CPU receives these outputs:
- a maskable request line, together with the number and level of the winning pin;
- a non-maskable request line, which the CPU acknowledges with a one-cycle pulse;
- a wake indication, raised after any enabled detection or a non-maskable edge, so that the chip can leave software standby.

The maskable request is forwarded only when the winning level is strictly above the CPU mask level input.

Register map (16-bit data):

| Address | Contents |
|---|---|
| 0 | Bit 0 selects the non-maskable edge: 1 = rising, 0 = falling. |
| 1 | Enable bits; bit n enables pin n. |
| 2 | Pending flags; bit n is the flag of pin n. |
| 3 | Sense fields for pins 7..0. |
| 4 | Sense fields for pins 15..8. |
| 5 to 8 | Priority levels, four pins per register. |

Sense fields are two bits per pin, with pin n at bits 2n+1:2n of the combined 32-bit value. The encoding is 00 = low level, 01 = falling edge, 10 = rising edge, 11 = both edges.

Priority levels sit in 4-bit slots, with pin n in slot n across the combined 64-bit value. Only the low three bits of each slot are used.

Top module: `ext_irq_ctrl`

## Requirements
- R1: With control bit 0 set to 1 the non-maskable request rises only on a rising pin edge; with it at 0, only on a falling edge; the other edge leaves `nmi_req` low.
- R2: While `nmi_req` is high, `irq_req` is low, whatever the mask level and the pending maskable requests; once the non-maskable request is acknowledged, the maskable request returns.
- R3: A pin's pending flag (address 2, bit n) is set according to its sense field: 00 while the pin is low, 01 on a falling edge, 10 on a rising edge, 11 on either edge; other transitions leave it clear.
- R4: A pin whose enable bit (address 1, bit n) is 0 never produces `irq_req`, although its flag is still set.
- R5: Among enabled pending pins with nonzero level, the highest level wins; equal levels go to the lowest pin number; a level of 0 never wins.
- R6: `irq_req` is asserted only when the winning level is strictly greater than `cpu_mask`.
- R7: Writing 0 to a status bit clears it only if the most recent status read returned that bit as 1; bits written 1, or not read as 1, are unchanged.
- R8: When a new detection and a valid clear fall in the same cycle, the flag stays set.
- R9: In low-level mode the request follows the synchronised pin: when the pin returns high the pin stops competing, though its flag stays set.
- R10: `wake` pulses for one cycle after a non-maskable edge and is high in the cycle after any detection on an enabled pin.
- R11: A cycle of `nmi_ack` without a fresh non-maskable edge clears `nmi_req`.
- R12: After reset all flags, enables, levels and outputs are zero and the idle-high pins produce no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin | input | 1 | Non-maskable request pin |
| irq_pins | input | 16 | Maskable request pins, bit n is pin n |
| cpu_mask | input | 3 | CPU mask level; requests need a higher level |
| nmi_ack | input | 1 | One-cycle acknowledge of the non-maskable request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe (marks status as read) |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data, combinational from rd_addr |
| nmi_req | output | 1 | Non-maskable request to the CPU |
| irq_req | output | 1 | Maskable request to the CPU |
| irq_id | output | 4 | Number of the winning maskable pin |
| irq_lvl | output | 3 | Level of the winning maskable pin |
| wake | output | 1 | Wake indication for leaving standby |

## Verification
Two collisions are the interesting cases.

The first is a flag clear that meets a new detection in the same cycle. The bench reads the status and then toggles a both-edge pin. It places the clearing write exactly two cycles later, which is the cycle in which the synchronised edge reaches the flag. It expects the flag to survive, and then shows that the same write without an edge does clear it.

The second is a non-maskable edge arriving while maskable requests are pending and forwarded. The bench expects the maskable line to drop in the same cycle as the non-maskable line rises, even with the mask at its top value. It expects the maskable line to return after the acknowledge.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int unsigned ADDR_CTRL   = 0;
  localparam int unsigned ADDR_EN     = 1;
  localparam int unsigned ADDR_STAT   = 2;
  localparam int unsigned ADDR_SENSE0 = 3;
  localparam int unsigned PRIO_SLOT   = 4;

  // Detection event for one synchronised sample pair.
  function automatic logic sense_hit(input logic [1:0] mode, input logic cur, input logic prev);
    case (mode)
      SENSE_LOW:  return !cur;
      SENSE_FALL: return !cur && prev;
      SENSE_RISE: return cur && !prev;
      default:    return cur != prev;
    endcase
  endfunction

  // Forwarding rule: strictly above the CPU mask.
  function automatic logic lvl_above(input logic [7:0] lvl, input logic [7:0] mask);
    return lvl > mask;
  endfunction

endpackage

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
#(
  parameter logic IDLE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_i,
  input  logic [1:0] mode_i,
  output logic       pin_low_o,
  output logic       evt_o
);

  logic sync1_q, sync2_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= IDLE;
      sync2_q <= IDLE;
      prev_q  <= IDLE;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign pin_low_o = !sync2_q;
  assign evt_o     = sense_hit(mode_i, sync2_q, prev_q);

  // R3: an edge mode event only follows a change of the synchronised pin
  assert_edge_changed_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_o && mode_i != SENSE_LOW) |-> (sync2_q != $past(sync2_q)));

endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eirq_pkg::*;
#(
  parameter int N_IRQ  = 16,
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int PRIO_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  input  logic [N_IRQ-1:0]         set_evt,
  output logic                     nmi_rise,
  output logic [N_IRQ-1:0]         en_vec,
  output logic [N_IRQ-1:0]         flags,
  output logic [2*N_IRQ-1:0]       sense_vec,
  output logic [PRIO_W*N_IRQ-1:0]  prio_vec
);

  localparam int SENSE_REGS   = (2 * N_IRQ) / DW;
  localparam int PRIO_PER_REG = DW / PRIO_SLOT;
  localparam int PRIO_REGS    = N_IRQ / PRIO_PER_REG;
  localparam int ADDR_PRIO0   = ADDR_SENSE0 + SENSE_REGS;

  logic [N_IRQ-1:0] seen_q;
  logic [N_IRQ-1:0] clr_mask;
  logic             stat_wr, stat_rd;

  assign stat_wr  = wr_en && (wr_addr == AW'(ADDR_STAT));
  assign stat_rd  = rd_en && (rd_addr == AW'(ADDR_STAT));
  assign clr_mask = stat_wr ? (~wr_data[N_IRQ-1:0] & seen_q) : '0;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_rise  <= 1'b0;
      en_vec    <= '0;
      sense_vec <= '0;
      prio_vec  <= '0;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADDR_CTRL)) nmi_rise <= wr_data[0];
      if (wr_addr == AW'(ADDR_EN))   en_vec   <= wr_data[N_IRQ-1:0];
      for (int r = 0; r < SENSE_REGS; r++)
        if (wr_addr == AW'(ADDR_SENSE0 + r)) sense_vec[r*DW +: DW] <= wr_data;
      for (int r = 0; r < PRIO_REGS; r++)
        for (int k = 0; k < PRIO_PER_REG; k++)
          if (wr_addr == AW'(ADDR_PRIO0 + r))
            prio_vec[(r*PRIO_PER_REG + k)*PRIO_W +: PRIO_W] <= wr_data[k*PRIO_SLOT +: PRIO_W];
    end
  end

  // Pending flags: detection beats clearing
  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      seen_q <= '0;
    end else begin
      flags  <= (flags & ~clr_mask) | set_evt;
      seen_q <= (stat_rd ? flags : seen_q) & ~clr_mask;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_CTRL)) rd_data[0] = nmi_rise;
    if (rd_addr == AW'(ADDR_EN))   rd_data[N_IRQ-1:0] = en_vec;
    if (rd_addr == AW'(ADDR_STAT)) rd_data[N_IRQ-1:0] = flags;
    for (int r = 0; r < SENSE_REGS; r++)
      if (rd_addr == AW'(ADDR_SENSE0 + r)) rd_data = sense_vec[r*DW +: DW];
    for (int r = 0; r < PRIO_REGS; r++)
      for (int k = 0; k < PRIO_PER_REG; k++)
        if (rd_addr == AW'(ADDR_PRIO0 + r))
          rd_data[k*PRIO_SLOT +: PRIO_W] = prio_vec[(r*PRIO_PER_REG + k)*PRIO_W +: PRIO_W];
  end

  // R7: a flag only falls when it had been read as set
  assert_clear_needs_read_R7: assert property (@(posedge clk) disable iff (rst)
    (($past(flags) & ~flags & ~$past(seen_q)) == '0));

  // R8: every detection leaves its flag set, even against a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|set_evt) |=> ((flags & $past(set_evt)) == $past(set_evt)));

endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter #(
  parameter int N_IRQ  = 16,
  parameter int PRIO_W = 3,
  localparam int IDW   = $clog2(N_IRQ)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_IRQ-1:0]        pend_vec,
  input  logic [N_IRQ-1:0]        en_vec,
  input  logic [PRIO_W*N_IRQ-1:0] prio_vec,
  output logic                    win_valid,
  output logic [IDW-1:0]          win_id,
  output logic [PRIO_W-1:0]       win_lvl
);

  logic [N_IRQ-1:0] cand;

  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    win_lvl   = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      cand[i] = pend_vec[i] && en_vec[i] && (prio_vec[i*PRIO_W +: PRIO_W] != '0);
      // strict compare keeps the lowest index on ties
      if (cand[i] && (!win_valid || prio_vec[i*PRIO_W +: PRIO_W] > win_lvl)) begin
        win_valid = 1'b1;
        win_id    = IDW'(i);
        win_lvl   = prio_vec[i*PRIO_W +: PRIO_W];
      end
    end
  end

  // R4/R5: the winner is pending, enabled and at a nonzero level
  assert_winner_legal_R4: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> (en_vec[win_id] && pend_vec[win_id] && win_lvl != '0));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int N_IRQ  = 16,
  parameter int DW     = 16,
  parameter int AW     = 4,
  parameter int PRIO_W = 3,
  localparam int IDW   = $clog2(N_IRQ)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pin,
  input  logic [N_IRQ-1:0]  irq_pins,
  input  logic [PRIO_W-1:0] cpu_mask,
  input  logic              nmi_ack,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              nmi_req,
  output logic              irq_req,
  output logic [IDW-1:0]    irq_id,
  output logic [PRIO_W-1:0] irq_lvl,
  output logic              wake
);

  logic [N_IRQ-1:0]        en_vec, flags, low_vec, evt_vec, pend_vec;
  logic [2*N_IRQ-1:0]      sense_vec;
  logic [PRIO_W*N_IRQ-1:0] prio_vec;
  logic                    nmi_rise, nmi_evt, nmi_low, nmi_pend_d, fwd;
  logic [1:0]              nmi_mode;
  logic                    win_valid;
  logic [IDW-1:0]          win_id;
  logic [PRIO_W-1:0]       win_lvl;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_pin
    eirq_detect #(.IDLE(1'b1)) u_det (
      .clk       (clk),
      .rst       (rst),
      .pin_i     (irq_pins[g]),
      .mode_i    (sense_vec[2*g +: 2]),
      .pin_low_o (low_vec[g]),
      .evt_o     (evt_vec[g])
    );
    // level mode competes on the live pin, edge modes on the flag
    assign pend_vec[g] = (sense_vec[2*g +: 2] == SENSE_LOW) ? low_vec[g] : flags[g];
  end

  assign nmi_mode = nmi_rise ? SENSE_RISE : SENSE_FALL;

  eirq_detect #(.IDLE(1'b1)) u_nmi_det (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (nmi_pin),
    .mode_i    (nmi_mode),
    .pin_low_o (nmi_low),
    .evt_o     (nmi_evt)
  );

  eirq_regs #(.N_IRQ(N_IRQ), .DW(DW), .AW(AW), .PRIO_W(PRIO_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .set_evt   (evt_vec),
    .nmi_rise  (nmi_rise),
    .en_vec    (en_vec),
    .flags     (flags),
    .sense_vec (sense_vec),
    .prio_vec  (prio_vec)
  );

  eirq_arbiter #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .pend_vec  (pend_vec),
    .en_vec    (en_vec),
    .prio_vec  (prio_vec),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_lvl   (win_lvl)
  );

  assign nmi_pend_d = (nmi_req && !nmi_ack) || nmi_evt;
  assign fwd        = win_valid && lvl_above(8'(win_lvl), 8'(cpu_mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_req <= 1'b0;
      irq_req <= 1'b0;
      irq_id  <= '0;
      irq_lvl <= '0;
      wake    <= 1'b0;
    end else begin
      nmi_req <= nmi_pend_d;
      irq_req <= fwd && !nmi_pend_d;
      irq_id  <= win_id;
      irq_lvl <= win_lvl;
      wake    <= nmi_evt || (|(evt_vec & en_vec));
    end
  end

  // R1: a falling-mode event happens only with the pin low
  assert_nmi_edge_R1: assert property (@(posedge clk) disable iff (rst)
    (nmi_evt && !nmi_rise) |-> nmi_low);

  // R2: the non-maskable request shuts out the maskable one
  assert_nmi_wins_R2: assert property (@(posedge clk) disable iff (rst)
    nmi_req |-> !irq_req);

  // R6: forwarded level exceeds the mask seen one cycle earlier
  assert_above_mask_R6: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl > $past(cpu_mask)));

  // R4: the forwarded pin was enabled when it was chosen
  assert_enabled_only_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((($past(en_vec) >> irq_id) & N_IRQ'(1)) != '0));

  // R11: acknowledge without a new edge drops the request
  assert_nmi_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (nmi_ack && !nmi_evt) |=> !nmi_req);

endmodule

// File: tb/tb_ext_irq_ctrl.sv
module tb_ext_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic        nmi_pin;
  logic [15:0] pins;
  logic [2:0]  cpu_mask;
  logic        nmi_ack;
  logic        wr_en, rd_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [15:0] wr_data, rd_data;
  logic        nmi_req, irq_req, wake;
  logic [3:0]  irq_id;
  logic [2:0]  irq_lvl;

  int checks = 0;
  int errors = 0;
  int wake_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ext_irq_ctrl dut (
    .clk(clk), .rst(rst), .nmi_pin(nmi_pin), .irq_pins(pins), .cpu_mask(cpu_mask),
    .nmi_ack(nmi_ack), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .nmi_req(nmi_req),
    .irq_req(irq_req), .irq_id(irq_id), .irq_lvl(irq_lvl), .wake(wake)
  );

  // idx[15:12] mode[11:10] prio[9:7] en[6] p0[5] p1[4] flag[3] req[2]
  localparam logic [15:0] VEC [0:8] = '{
    {4'd3,  2'b01, 3'd5, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00},
    {4'd3,  2'b01, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00},
    {4'd7,  2'b10, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00},
    {4'd7,  2'b10, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00},
    {4'd12, 2'b11, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00},
    {4'd12, 2'b11, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00},
    {4'd0,  2'b00, 3'd1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b00},
    {4'd5,  2'b01, 3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00},
    {4'd9,  2'b01, 3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00}
  };

  always @(negedge clk) if (wake) wake_cnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_all();
    logic [15:0] v;
    rd(4'd2, v);
    wr(4'd2, ~v);
  endtask

  task automatic cfg(input logic [31:0] sv, input logic [63:0] pv, input logic [15:0] en);
    wr(4'd3, sv[15:0]);
    wr(4'd4, sv[31:16]);
    for (int r = 0; r < 4; r++) wr(4'(5 + r), pv[r*16 +: 16]);
    wr(4'd1, en);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R12 actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] sv;
    logic [63:0] pv;
    rst = 1'b1; nmi_pin = 1'b1; pins = '1; cpu_mask = 3'd0; nmi_ack = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    cyc(4);
    rst = 1'b0;
    cyc(4);

    // R12 reset state
    chk("R12 irq_req", irq_req, 0);
    chk("R12 nmi_req", nmi_req, 0);
    chk("R12 wake", wake, 0);
    rd(4'd2, d); chk("R12 status", d, 0);
    rd(4'd1, d); chk("R12 enable", d, 0);

    // Vector table: one pin, one mode, one transition each (R3 R4 R5)
    for (int i = 0; i < 9; i++) begin
      logic [15:0] v;
      int idx;
      v = VEC[i];
      idx = int'(v[15:12]);
      wr(4'd1, 16'h0);
      pins = '1;
      cyc(6);
      clear_all();
      sv = '0; sv[idx*2 +: 2] = v[11:10];
      pv = '0; pv[idx*4 +: 3] = v[9:7];
      cfg(sv, pv, 16'h0);
      pins[idx] = v[5];
      cyc(6);
      clear_all();
      wr(4'd1, v[6] ? (16'h1 << idx) : 16'h0);
      pins[idx] = v[4];
      cyc(6);
      rd(4'd2, d);
      chk($sformatf("R3 vec%0d flag", i), d[idx], v[3]);
      chk($sformatf("R4/R5 vec%0d req", i), irq_req, v[2]);
      if (v[2]) begin
        chk($sformatf("R5 vec%0d id", i), irq_id, idx);
        chk($sformatf("R5 vec%0d lvl", i), irq_lvl, v[9:7]);
      end
    end

    // Priority and tie-break (R5)
    wr(4'd1, 16'h0);
    pins = '1;
    cyc(6);
    clear_all();
    sv = '0;
    sv[2*2 +: 2] = 2'b01; sv[4*2 +: 2] = 2'b01; sv[10*2 +: 2] = 2'b01; sv[11*2 +: 2] = 2'b01;
    pv = '0;
    pv[2*4 +: 3] = 3'd3; pv[4*4 +: 3] = 3'd6; pv[10*4 +: 3] = 3'd6; pv[11*4 +: 3] = 3'd6;
    cfg(sv, pv, 16'h0404);
    pins[2] = 1'b0; pins[4] = 1'b0; pins[10] = 1'b0; pins[11] = 1'b0;
    cyc(6);
    chk("R5 highest level id", irq_id, 10);
    chk("R5 highest level lvl", irq_lvl, 6);
    wr(4'd1, 16'h0C14);
    cyc(3);
    chk("R5 tie lowest id", irq_id, 4);

    // Mask comparison (R6)
    cpu_mask = 3'd6; cyc(3);
    chk("R6 equal to mask blocked", irq_req, 0);
    cpu_mask = 3'd5; cyc(3);
    chk("R6 above mask forwarded", irq_req, 1);

    // Non-maskable edge select, precedence, wake, acknowledge (R1 R2 R10 R11)
    wr(4'd0, 16'h0001);
    cyc(3);
    nmi_pin = 1'b0; cyc(6);
    chk("R1 falling ignored in rising mode", nmi_req, 0);
    wake_cnt = 0;
    nmi_pin = 1'b1; cyc(6);
    chk("R1 rising edge requested", nmi_req, 1);
    chk("R2 maskable held off", irq_req, 0);
    chk("R10 wake one pulse", wake_cnt, 1);
    cpu_mask = 3'd7; cyc(3);
    chk("R2 mask has no effect", nmi_req, 1);
    cpu_mask = 3'd5;
    @(negedge clk); nmi_ack = 1'b1;
    @(negedge clk); nmi_ack = 1'b0;
    cyc(2);
    chk("R11 ack clears", nmi_req, 0);
    chk("R2 maskable returns", irq_req, 1);

    // Clear handshake (R7)
    wr(4'd2, 16'h0000);
    cyc(2);
    rd(4'd2, d);
    chk("R7 clear without read ignored", d, 16'h0C14);
    wr(4'd2, 16'hFFFB);
    rd(4'd2, d);
    chk("R7 read then clear one bit", d, 16'h0C10);

    // Level mode loses the request when the pin rises (R9)
    pv[0 +: 3] = 3'd7;
    cfg(sv, pv, 16'h0C15);
    pins[0] = 1'b0; cyc(6);
    chk("R9 low level wins", irq_id, 0);
    chk("R9 low level lvl", irq_lvl, 7);
    pins[0] = 1'b1; cyc(6);
    chk("R9 request gone after high", irq_id, 4);
    rd(4'd2, d);
    chk("R9 flag kept", d[0], 1);

    // Clear colliding with a new edge (R8)
    sv[1*2 +: 2] = 2'b11;
    pv[1*4 +: 3] = 3'd1;
    cfg(sv, pv, 16'h0C15);
    pins[1] = 1'b0; cyc(6);
    rd(4'd2, d);
    chk("R3 both-edge fall flag", d[1], 1);
    @(negedge clk); pins[1] = 1'b1;
    @(negedge clk);
    wr(4'd2, 16'hFFFD);
    cyc(2);
    rd(4'd2, d);
    chk("R8 edge beats clear", d[1], 1);
    wr(4'd2, 16'hFFFD);
    rd(4'd2, d);
    chk("R7 clear without edge", d[1], 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule